// File: doc/BRIEF.md
# Reconfigurable Two-Port Block RAM

This block is a synchronous RAM built around a single storage array of 512 words of 36 bits. Two ports, A and B, each carry their own enable, write enable, address and data. All storage and output registers use one clock. A static two-bit mode input reshapes the array into one of four uses:

- **Full two-port.** Either port may read or write.
- **Write/read pair.** Port A only writes and port B only reads.
- **Partitioned.** Two independent single-port memories meet at a programmable boundary.
- **Double-width.** One single-port memory of 256 words by 72 bits.

Every write also performs a read in the same cycle. A per-port option decides what that read returns: the stored contents from before the write, or the data being written.

The storage array has no reset. Read data and the collision flag are registered, so a read result appears one clock after its request. The mode, the boundary and the per-port options are set up while both ports are idle and then left unchanged.

Top module: `dpram_mux`

## Requirements
- R1: After reset, `a_rdata`, `b_rdata` and `coll` are all zero.
- R2: In mode 0 (full two-port), each port reads or writes any of the 512 words independently. For an enabled port, read data appears on the clock after the request.
- R3: A port that writes with its `*_wbr` input at 1 returns the data it is writing on the next clock. With `*_wbr` at 0 it returns the word's contents from before the write.
- R4: In mode 0, when one port reads a word that the other port writes in the same cycle, the reading port returns the contents from before the write.
- R5: In mode 0, when both ports write the same address in one cycle, port A's data is kept. `coll` is then 1 for exactly the following cycle.
- R6: In mode 1 (write/read pair), enabled port A cycles write only when `a_we` is 1, and `a_rdata` becomes zero. Port B only reads, and `b_we` has no effect on storage.
- R7: In mode 2 (partitioned), port A address i reaches physical word i. Port B address j reaches physical word `split_at`+j.
- R8: In mode 2, a port A address of `split_at` or more, or a port B address of 512−`split_at` or more, stores nothing and reads zero.
- R9: In mode 3 (double-width), `a_addr[7:0]` selects word k. `a_wdata` and `a_rdata` map to physical word 2k, and `b_wdata` and `b_rdata` map to physical word 2k+1. Port A's enable, write enable and `a_wbr` control both halves.
- R10: A port whose enable is low keeps its previous read data. In mode 3 this applies to both read outputs while `a_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Active-low reset of the output registers |
| mode | input | 2 | 0 full two-port, 1 write/read pair, 2 partitioned, 3 double-width |
| split_at | input | 10 | Size of port A's region in mode 2 (0 to 512) |
| a_wbr | input | 1 | Port A write cycles return the new data when 1 |
| b_wbr | input | 1 | Port B write cycles return the new data when 1 |
| a_en | input | 1 | Port A access enable |
| a_we | input | 1 | Port A write enable |
| a_addr | input | 9 | Port A word address |
| a_wdata | input | 36 | Port A write data, or low half in mode 3 |
| a_rdata | output | 36 | Port A read data, or low half in mode 3 |
| b_en | input | 1 | Port B access enable |
| b_we | input | 1 | Port B write enable |
| b_addr | input | 9 | Port B word address |
| b_wdata | input | 36 | Port B write data, or high half in mode 3 |
| b_rdata | output | 36 | Port B read data, or high half in mode 3 |
| coll | output | 1 | Pulses for one cycle after a same-address double write |

## Verification
Same-word contention is the hardest condition to reach from the ports. It covers both ports writing one word, and one port reading a word while the other writes it. With random addresses over 512 words this almost never happens. Random phases therefore confine both addresses to eight words about half the time, and directed cycles force each contention case with both settings of the read-during-write option. The partition edges are reached by directed accesses on both sides of `split_at`, on each port.

// File: rtl/dpram_mux.sv
`timescale 1ns/1ps
module dpram_mux #(
  parameter int AW = 9,
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic [AW:0]   split_at,
  input  logic          a_wbr,
  input  logic          b_wbr,
  input  logic          a_en,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_en,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata,
  output logic          coll
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] DEPTH_W = (AW+1)'(DEPTH);
  localparam logic [1:0] M_TDP = 2'd0, M_SDP = 2'd1, M_SPLIT = 2'd2, M_WIDE = 2'd3;

  logic [DW-1:0] mem [DEPTH];

  wire [AW:0]   b_off  = {1'b0, b_addr} + split_at;
  wire          a_in   = {1'b0, a_addr} < split_at;
  wire          b_in   = {1'b0, b_addr} < (DEPTH_W - split_at);
  wire [AW-1:0] w_base = {a_addr[AW-2:0], 1'b0};

  logic [AW-1:0] ia, ib;
  logic a_wr, b_wr, a_rd, b_rd, a_z, b_z, b_sel;

  always_comb begin
    ia = a_addr;  ib = b_addr;
    a_wr = a_en & a_we;  b_wr = b_en & b_we;
    a_rd = a_en;  b_rd = b_en;
    a_z = 1'b0;   b_z = 1'b0;
    b_sel = b_wbr;
    case (mode)
      M_SDP: begin
        a_z  = 1'b1;
        b_wr = 1'b0;
      end
      M_SPLIT: begin
        a_z  = ~a_in;
        a_wr = a_en & a_we & a_in;
        ib   = b_off[AW-1:0];
        b_z  = ~b_in;
        b_wr = b_en & b_we & b_in;
      end
      M_WIDE: begin
        ia    = w_base;
        ib    = w_base | AW'(1);
        b_wr  = a_en & a_we;
        b_rd  = a_en;
        b_sel = a_wbr;
      end
      default: ;
    endcase
  end

  wire same    = a_wr & b_wr & (ia == ib);
  wire b_store = b_wr & ~same;
  wire coll_d  = (mode == M_TDP) & same;

  always_ff @(posedge clk) begin
    if (a_wr)    mem[ia] <= a_wdata;
    if (b_store) mem[ib] <= b_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_rdata <= '0;
      b_rdata <= '0;
      coll    <= 1'b0;
    end else begin
      coll <= coll_d;
      if (a_rd) a_rdata <= a_z ? '0 : (a_wr && a_wbr) ? a_wdata : mem[ia];
      if (b_rd) b_rdata <= b_z ? '0 : (b_wr && b_sel) ? b_wdata : mem[ib];
    end
  end
endmodule

// File: rtl/dpram_mux_chk.sv
`timescale 1ns/1ps
module dpram_mux_chk #(
  parameter int AW = 9,
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode,
  input logic [AW:0]   split_at,
  input logic          a_wbr,
  input logic          a_en,
  input logic          a_we,
  input logic [AW-1:0] a_addr,
  input logic [DW-1:0] a_wdata,
  input logic [DW-1:0] a_rdata,
  input logic          b_en,
  input logic          b_we,
  input logic [AW-1:0] b_addr,
  input logic          coll
);
  // R5
  coll_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    coll |-> $past(mode == 2'd0 && a_en && a_we && b_en && b_we && a_addr == b_addr));

  // R6
  sdp_a_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && a_en) |=> a_rdata == '0);

  // R8
  split_oob_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && a_en && ({1'b0, a_addr} >= split_at)) |=> a_rdata == '0);

  // R10
  a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !a_en |=> $stable(a_rdata));

  // R3
  a_wbr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && a_en && a_we && a_wbr) |=> a_rdata == $past(a_wdata));
endmodule

bind dpram_mux dpram_mux_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .split_at(split_at), .a_wbr(a_wbr),
  .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
  .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .coll(coll)
);

// File: tb/dpram_mux_bench.sv
`timescale 1ns/1ps
module dpram_mux_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [9:0] split_at = 10'd256;
  logic a_wbr = 1'b0, b_wbr = 1'b0;
  logic a_en = 1'b0, a_we = 1'b0, b_en = 1'b0, b_we = 1'b0;
  logic [8:0] a_addr = '0, b_addr = '0;
  logic [35:0] a_wdata = '0, b_wdata = '0;
  logic [35:0] a_rdata, b_rdata;
  logic coll;

  int n_cmp = 0, n_bad = 0;
  logic [35:0] ph [512];
  logic [35:0] ea = '0, eb = '0;
  logic ec = 1'b0;

  always #10 clk = ~clk;

  dpram_mux u_dpram_mux (
    .clk(clk), .rst_n(rst_n), .mode(mode), .split_at(split_at),
    .a_wbr(a_wbr), .b_wbr(b_wbr),
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata),
    .coll(coll)
  );

  function automatic logic [35:0] rnd36();
    return {$urandom, $urandom};
  endfunction

  task automatic cmp(input string tag, input string what, input logic [35:0] act, input logic [35:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag);
    int sp, bi, wi;
    logic aok, bok;
    ec = 1'b0;
    case (mode)
      2'd0: begin
        if (a_en) ea = (a_we && a_wbr) ? a_wdata : ph[a_addr];
        if (b_en) eb = (b_we && b_wbr) ? b_wdata : ph[b_addr];
        ec = a_en && a_we && b_en && b_we && a_addr == b_addr;
        if (b_en && b_we && !ec) ph[b_addr] = b_wdata;
        if (a_en && a_we) ph[a_addr] = a_wdata;
      end
      2'd1: begin
        if (a_en) ea = '0;
        if (b_en) eb = ph[b_addr];
        if (a_en && a_we) ph[a_addr] = a_wdata;
      end
      2'd2: begin
        sp = int'(split_at);
        aok = int'(a_addr) < sp;
        bok = int'(b_addr) < 512 - sp;
        bi = sp + int'(b_addr);
        if (a_en) ea = !aok ? '0 : (a_we && a_wbr) ? a_wdata : ph[a_addr];
        if (b_en) eb = !bok ? '0 : (b_we && b_wbr) ? b_wdata : ph[bi];
        if (a_en && a_we && aok) ph[a_addr] = a_wdata;
        if (b_en && b_we && bok) ph[bi] = b_wdata;
      end
      default: begin
        wi = 2 * int'(a_addr[7:0]);
        if (a_en) begin
          ea = (a_we && a_wbr) ? a_wdata : ph[wi];
          eb = (a_we && a_wbr) ? b_wdata : ph[wi+1];
          if (a_we) begin ph[wi] = a_wdata; ph[wi+1] = b_wdata; end
        end
      end
    endcase
    @(posedge clk);
    @(negedge clk);
    cmp(tag, "a_rdata", a_rdata, ea);
    cmp(tag, "b_rdata", b_rdata, eb);
    cmp(tag, "coll", {35'd0, coll}, {35'd0, ec});
  endtask

  task automatic idle(input string tag);
    a_en = 0; b_en = 0; a_we = 0; b_we = 0;
    step(tag);
  endtask

  task automatic rnd(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      logic narrow;
      narrow = $urandom_range(1);
      a_en = $urandom_range(3) != 0; b_en = $urandom_range(3) != 0;
      a_we = $urandom_range(1);      b_we = $urandom_range(1);
      a_wbr = $urandom_range(1);     b_wbr = $urandom_range(1);
      a_addr = narrow ? 9'($urandom_range(7)) : 9'($urandom);
      b_addr = narrow ? 9'($urandom_range(7)) : 9'($urandom);
      if (mode == 2'd2 && narrow) b_addr = 9'(int'(512 - split_at) - 4 + $urandom_range(7));
      a_wdata = rnd36(); b_wdata = rnd36();
      step(tag);
    end
    idle(tag);
  endtask

  task automatic acc(input logic ae, aw, input int aa, input logic be, bw, input int ba, input string tag);
    a_en = ae; a_we = aw; a_addr = 9'(aa); a_wdata = rnd36();
    b_en = be; b_we = bw; b_addr = 9'(ba); b_wdata = rnd36();
    step(tag);
  endtask

  initial begin
    process::self().srandom(32'd20240607);
    repeat (3) @(negedge clk);
    // R1
    cmp("R1", "a_rdata", a_rdata, '0);
    cmp("R1", "b_rdata", b_rdata, '0);
    cmp("R1", "coll", {35'd0, coll}, 36'd0);
    rst_n = 1'b1;
    @(negedge clk);
    cmp("R1", "a_rdata", a_rdata, '0);

    // R2: fill the whole array through both ports at once
    for (int k = 0; k < 256; k++) acc(1, 1, 2*k, 1, 1, 2*k+1, "R2");
    for (int k = 0; k < 16; k++) acc(1, 0, $urandom_range(511), 1, 0, $urandom_range(511), "R2");

    // R3: read-during-write options on both ports
    a_wbr = 0; b_wbr = 1; acc(1, 1, 20, 1, 1, 21, "R3");
    a_wbr = 1; b_wbr = 0; acc(1, 1, 22, 1, 1, 23, "R3");

    // R4: one port reads while the other writes the same word
    a_wbr = 1; b_wbr = 1;
    acc(1, 1, 30, 1, 0, 30, "R4");
    acc(1, 0, 31, 1, 1, 31, "R4");
    acc(1, 0, 30, 1, 0, 31, "R4");

    // R5: both ports write one word, A wins, then a clean cycle
    acc(1, 1, 40, 1, 1, 40, "R5");
    acc(1, 0, 40, 1, 0, 40, "R5");
    a_wbr = 0; b_wbr = 0;
    acc(1, 1, 41, 1, 1, 41, "R5");
    acc(0, 0, 0, 0, 0, 0, "R5");

    // R10: idle ports keep their outputs
    idle("R10"); idle("R10");
    acc(1, 0, 5, 0, 0, 0, "R10");
    acc(0, 1, 6, 1, 0, 7, "R10");

    rnd(800, "R2");

    mode = 2'd1;
    // R6: b_we must not store, a reads zero
    acc(1, 0, 50, 1, 1, 50, "R6");
    acc(1, 1, 51, 1, 1, 52, "R6");
    acc(0, 0, 0, 1, 0, 52, "R6");
    rnd(800, "R6");

    mode = 2'd2; split_at = 10'd100;
    // R7 and R8: both sides of both region edges
    acc(1, 1, 99, 1, 1, 411, "R7");
    acc(1, 0, 99, 1, 0, 411, "R7");
    acc(1, 1, 100, 1, 1, 412, "R8");
    acc(1, 0, 0, 1, 0, 0, "R7");
    idle("R8");
    mode = 2'd0;
    acc(1, 0, 100, 1, 0, 511, "R8");
    acc(1, 0, 99, 1, 0, 0, "R8");
    idle("R8");
    mode = 2'd2;
    rnd(800, "R7");
    split_at = 10'd0;   rnd(100, "R8");
    split_at = 10'd512; rnd(100, "R8");
    split_at = 10'd333; rnd(400, "R7");

    mode = 2'd3;
    // R9: double-width words
    a_wbr = 0; acc(1, 1, 300, 0, 0, 0, "R9");
    acc(1, 0, 44, 0, 0, 0, "R9");
    a_wbr = 1; b_wbr = 0; acc(1, 1, 45, 0, 0, 0, "R9");
    idle("R10");
    idle("R9");
    mode = 2'd0;
    acc(1, 0, 88, 1, 0, 89, "R9");
    idle("R9");
    mode = 2'd3;
    rnd(800, "R9");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2ms;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule